// File: doc/BRIEF.md
# Early-Output AND Stage with Backward Cancellation

This block is a cycle-level model of a delay-insensitive pipeline stage that combines two dual-rail channels with an AND. Each channel reaches the join point through its own chain of single-item cells. Each source talks to its chain with a four-phase return-to-zero handshake. The join sends its result to the consumer under the same protocol.

When the token at the head of one chain is a zero, the result is already known. The join emits zero at once and places a cancel item in the other chain. That cancel moves back toward its source one cell per cycle. When it meets the forward-moving token of that channel, the two destroy each other. This happens whether they meet mid-chain, arrive at the same empty cell in the same cycle, or meet at the source boundary. At the source boundary the token is acknowledged to its source as usual. The late input therefore never stalls the join, and no arbiter decides any race.

Top module: `early_and_cancel_pipe`

## Requirements
- R1: Channel coding on every port is two bits: 2'b00 is empty, 2'b01 is logic zero, 2'b10 is logic one. An input holding 2'b11 is not accepted and is never acknowledged. `y_rail` never shows 2'b11.
- R2: While `rst_n` is low and right after it rises, `a_ack`, `b_ack` and `y_rail` are all zero.
- R3: An input acknowledge rises only one cycle after a zero or one code was present on that input. It stays high while the code stays present. It falls in the cycle after the input returns to 2'b00.
- R4: A result on `y_rail` holds unchanged until `y_ack` is high. It becomes 2'b00 in the next cycle. No new result appears while `y_ack` stays high.
- R5: A result of one is never produced before both input tokens have been presented.
- R6: Each operation consumes one item from each channel and produces a result equal to the AND of the two input values.
- R7: When one input is zero, its zero result appears without waiting for the other channel's token to be presented.
- R8: The cancelled token of the undecided channel is still acknowledged to its source when presented. It is destroyed by the cancel item and produces no extra result. This holds wherever the two meet, including a same-cycle arrival at one empty cell.
- R9: With both chains empty, two ones presented in the same cycle give the result max(DEPTH_A, DEPTH_B)+1 clock edges later.
- R10: Over any sequence of operations, each source is acknowledged exactly once per operation and exactly one result is produced per operation. After the last one, the ports stay idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modelling clock, one step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_rail | input | 2 | Dual-rail data from source A |
| a_ack | output | 1 | Four-phase acknowledge to source A |
| b_rail | input | 2 | Dual-rail data from source B |
| b_ack | output | 1 | Four-phase acknowledge to source B |
| y_rail | output | 2 | Dual-rail AND result to the consumer |
| y_ack | input | 1 | Four-phase acknowledge from the consumer |

## Verification
The hardest event to reach from the ports is a cancel item meeting its token inside the chain, and in particular both entering one empty cell in the same cycle. Neither event is visible directly. The stimulus presents a zero on one channel and delays the other channel's one by a sweep of small offsets, so the meeting point walks across every cell and the source boundary. Long delays park the cancel at the source. Correctness then shows as one result and exactly one acknowledge per channel per operation, followed by a silent drain.

// File: rtl/ecp_pkg.sv
// Shared types for the early-output cancelling pipeline.
// Assumes one bit of payload per dual-rail channel.
package ecp_pkg;

    // Dual-rail code words.
    localparam logic [1:0] DR_NULL = 2'b00;
    localparam logic [1:0] DR_ZERO = 2'b01;
    localparam logic [1:0] DR_ONE  = 2'b10;

    // What a pipeline cell currently holds.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_TOKEN = 2'd1,
        SLOT_ANTI  = 2'd2
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic       val;
    } slot_t;

    localparam slot_t SLOT_NONE = '{kind: SLOT_EMPTY, val: 1'b0};

    // Output handshake phases of the join.
    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_HOLD = 2'd1,
        OUT_RTZ  = 2'd2
    } out_phase_e;

    function automatic logic dr_is_data(input logic [1:0] code);
        return (code == DR_ZERO) || (code == DR_ONE);
    endfunction

    function automatic logic [1:0] dr_encode(input logic bit_val);
        return bit_val ? DR_ONE : DR_ZERO;
    endfunction

endpackage

// File: rtl/ecp_cell.sv
// One pipeline cell holding nothing, a forward token or a backward cancel.
// Assumes the neighbours compute the leave strobes from the same current
// state, so every item is moved or destroyed in exactly one place.
// A token and a cancel that enter the same empty cell together destroy
// each other, which removes the need for any arbitration.
module ecp_cell
    import ecp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fwd_in,
    input  logic  fwd_val,
    input  logic  back_in,
    input  logic  tok_leave,
    input  logic  anti_leave,
    output slot_t q
);

    slot_t d;

    // Next content from the current content and the offers on each side.
    always_comb begin
        d = q;
        case (q.kind)
            SLOT_TOKEN: if (tok_leave)  d = SLOT_NONE;
            SLOT_ANTI:  if (anti_leave) d = SLOT_NONE;
            default: begin
                if (fwd_in && back_in) d = SLOT_NONE;
                else if (fwd_in)       d = '{kind: SLOT_TOKEN, val: fwd_val};
                else if (back_in)      d = '{kind: SLOT_ANTI,  val: 1'b0};
                else                   d = SLOT_NONE;
            end
        endcase
    end

    // Cell register with synchronous reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SLOT_NONE;
        else        q <= d;
    end

endmodule

// File: rtl/ecp_chain.sv
// A chain of DEPTH cells between one dual-rail source and the join.
// Tokens move toward the head and cancels move toward the source, one cell
// per cycle. A cancel parked in the first cell waits for the source's
// token, destroys it, and the token is acknowledged as if accepted.
// Assumes DEPTH >= 1 and a source that obeys the four-phase protocol.
module ecp_chain
    import ecp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_rail,
    output logic       src_ack,
    output slot_t      head,
    input  logic       head_take,
    input  logic       head_anti
);

    localparam int LAST = DEPTH - 1;

    slot_t cell_q [DEPTH];
    logic  ack_q;
    logic  src_fresh;
    logic  src_take;

    assign src_fresh = !ack_q && dr_is_data(src_rail);
    assign src_take  = src_fresh && (cell_q[0].kind != SLOT_TOKEN);

    // Source acknowledge: set on take, cleared once the source is back to empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ack_q <= 1'b0;
        else if (src_take)                     ack_q <= 1'b1;
        else if (ack_q && src_rail == DR_NULL) ack_q <= 1'b0;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic fwd_in;
        logic fwd_val;
        logic back_in;
        logic tok_leave;
        logic anti_leave;

        if (i == 0) begin : g_first
            assign fwd_in     = src_fresh;
            assign fwd_val    = src_rail[1];
            assign anti_leave = src_fresh;
        end else begin : g_inner_left
            assign fwd_in     = cell_q[i-1].kind == SLOT_TOKEN;
            assign fwd_val    = cell_q[i-1].val;
            assign anti_leave = cell_q[i-1].kind != SLOT_ANTI;
        end

        if (i == LAST) begin : g_head
            assign back_in   = head_anti;
            assign tok_leave = head_take;
        end else begin : g_inner_right
            assign back_in   = cell_q[i+1].kind == SLOT_ANTI;
            assign tok_leave = cell_q[i+1].kind != SLOT_TOKEN;
        end

        ecp_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .fwd_in     (fwd_in),
            .fwd_val    (fwd_val),
            .back_in    (back_in),
            .tok_leave  (tok_leave),
            .anti_leave (anti_leave),
            .q          (cell_q[i])
        );
    end

    assign head    = cell_q[LAST];
    assign src_ack = ack_q;

endmodule

// File: rtl/ecp_join.sv
// Early-output AND join between two chain heads and the consumer.
// Fires when both heads hold tokens, or when one head holds a zero and the
// other head is empty; in the latter case it injects a cancel into the
// empty head. A head holding a cancel blocks early firing, so a cell never
// has to hold two items. Assumes a four-phase consumer.
module ecp_join
    import ecp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slot_t      head_a,
    input  slot_t      head_b,
    input  logic       y_ack,
    output logic       take_a,
    output logic       take_b,
    output logic       anti_a,
    output logic       anti_b,
    output logic [1:0] y_rail
);

    out_phase_e phase_q;
    logic       res_q;
    logic       ready;
    logic       tok_a;
    logic       tok_b;
    logic       both;
    logic       early_a;
    logic       early_b;
    logic       fire;

    // Firing decision from the two heads.
    always_comb begin
        ready   = (phase_q == OUT_IDLE) && !y_ack;
        tok_a   = head_a.kind == SLOT_TOKEN;
        tok_b   = head_b.kind == SLOT_TOKEN;
        both    = tok_a && tok_b;
        early_a = tok_a && !head_a.val && (head_b.kind == SLOT_EMPTY);
        early_b = tok_b && !head_b.val && (head_a.kind == SLOT_EMPTY);
        fire    = ready && (both || early_a || early_b);
        take_a  = ready && (both || early_a);
        take_b  = ready && (both || early_b);
        anti_b  = ready && early_a;
        anti_a  = ready && early_b;
    end

    // Output four-phase sequence and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= OUT_IDLE;
            res_q   <= 1'b0;
        end else begin
            case (phase_q)
                OUT_IDLE: if (fire) begin
                    phase_q <= OUT_HOLD;
                    res_q   <= both && head_a.val && head_b.val;
                end
                OUT_HOLD: if (y_ack)  phase_q <= OUT_RTZ;
                OUT_RTZ:  if (!y_ack) phase_q <= OUT_IDLE;
                default:  phase_q <= OUT_IDLE;
            endcase
        end
    end

    assign y_rail = (phase_q == OUT_HOLD) ? dr_encode(res_q) : DR_NULL;

endmodule

// File: rtl/early_and_cancel_pipe.sv
// Top level: two cancelling chains feeding an early-output AND join.
// Chain lengths are independent parameters (each at least one cell).
module early_and_cancel_pipe
    import ecp_pkg::*;
#(
    parameter int DEPTH_A = 4,
    parameter int DEPTH_B = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] a_rail,
    output logic       a_ack,
    input  logic [1:0] b_rail,
    output logic       b_ack,
    output logic [1:0] y_rail,
    input  logic       y_ack
);

    slot_t head_a;
    slot_t head_b;
    logic  take_a;
    logic  take_b;
    logic  anti_a;
    logic  anti_b;

    ecp_chain #(.DEPTH(DEPTH_A)) u_chain_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_rail  (a_rail),
        .src_ack   (a_ack),
        .head      (head_a),
        .head_take (take_a),
        .head_anti (anti_a)
    );

    ecp_chain #(.DEPTH(DEPTH_B)) u_chain_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_rail  (b_rail),
        .src_ack   (b_ack),
        .head      (head_b),
        .head_take (take_b),
        .head_anti (anti_b)
    );

    ecp_join u_join (
        .clk    (clk),
        .rst_n  (rst_n),
        .head_a (head_a),
        .head_b (head_b),
        .y_ack  (y_ack),
        .take_a (take_a),
        .take_b (take_b),
        .anti_a (anti_a),
        .anti_b (anti_b),
        .y_rail (y_rail)
    );

endmodule

// File: rtl/ecp_checker.sv
// Protocol checks on the ports of early_and_cancel_pipe, bound below.
// Assumes the environment keeps its own side of both handshakes.
module ecp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] a_rail,
    input logic       a_ack,
    input logic [1:0] b_rail,
    input logic       b_ack,
    input logic [1:0] y_rail,
    input logic       y_ack
);

    // R1
    y_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_rail != 2'b11);

    // R3
    a_ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_ack) |-> ($past(a_rail) == 2'b01 || $past(a_rail) == 2'b10));

    // R3
    b_ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_ack) |-> ($past(b_rail) == 2'b01 || $past(b_rail) == 2'b10));

    // R3
    a_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ack && a_rail != 2'b00) |=> a_ack);

    // R3
    b_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_ack && b_rail != 2'b00) |=> b_ack);

    // R3
    a_ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_ack) |-> $past(a_rail) == 2'b00);

    // R3
    b_ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_ack) |-> $past(b_rail) == 2'b00);

    // R4
    y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_rail != 2'b00 && !y_ack) |=> $stable(y_rail));

    // R4
    y_rtz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_rail != 2'b00 && y_ack) |=> y_rail == 2'b00);

    // R4
    y_no_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_rail == 2'b00 && y_ack) |=> y_rail == 2'b00);

endmodule

bind early_and_cancel_pipe ecp_checker u_ecp_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_rail (a_rail),
    .a_ack  (a_ack),
    .b_rail (b_rail),
    .b_ack  (b_ack),
    .y_rail (y_rail),
    .y_ack  (y_ack)
);

// File: tb/tb_early_and_cancel_pipe.sv
module tb_early_and_cancel_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int DA   = 4;
    localparam int DB   = 3;
    localparam int LAT  = ((DA > DB) ? DA : DB) + 1;
    localparam int NVEC = 16;

    // {a, b, a_delay[5:0], b_delay[5:0], sink_hold[3:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 6'd0,  6'd0,  4'd0},
        {1'b1, 1'b0, 6'd0,  6'd0,  4'd0},
        {1'b0, 1'b1, 6'd0,  6'd0,  4'd0},
        {1'b0, 1'b0, 6'd0,  6'd0,  4'd0},
        {1'b0, 1'b1, 6'd0,  6'd20, 4'd0},
        {1'b1, 1'b0, 6'd25, 6'd0,  4'd2},
        {1'b0, 1'b1, 6'd0,  6'd1,  4'd0},
        {1'b0, 1'b1, 6'd0,  6'd2,  4'd0},
        {1'b0, 1'b1, 6'd0,  6'd3,  4'd0},
        {1'b0, 1'b1, 6'd0,  6'd4,  4'd0},
        {1'b1, 1'b0, 6'd2,  6'd0,  4'd0},
        {1'b1, 1'b0, 6'd3,  6'd0,  4'd0},
        {1'b1, 1'b1, 6'd0,  6'd15, 4'd3},
        {1'b1, 1'b1, 6'd12, 6'd0,  4'd0},
        {1'b0, 1'b0, 6'd5,  6'd0,  4'd0},
        {1'b1, 1'b0, 6'd0,  6'd6,  4'd4}
    };

    logic       clk;
    logic       rst_n;
    logic [1:0] a_rail;
    logic [1:0] b_rail;
    logic [1:0] y_rail;
    logic       a_ack;
    logic       b_ack;
    logic       y_ack;

    int cyc    = 0;
    int n_chk  = 0;
    int n_fail = 0;
    int n_a    = 0;
    int n_b    = 0;
    int n_y    = 0;

    early_and_cancel_pipe #(.DEPTH_A(DA), .DEPTH_B(DB)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_rail (a_rail),
        .a_ack  (a_ack),
        .b_rail (b_rail),
        .b_ack  (b_ack),
        .y_rail (y_rail),
        .y_ack  (y_ack)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_a(input logic v, input int dly, output int t_pres);
        repeat (dly) @(negedge clk);
        a_rail = v ? 2'b10 : 2'b01;
        t_pres = cyc;
        do @(negedge clk); while (!a_ack);
        n_a++;
        a_rail = 2'b00;
        do @(negedge clk); while (a_ack);
    endtask

    task automatic send_b(input logic v, input int dly, output int t_pres);
        repeat (dly) @(negedge clk);
        b_rail = v ? 2'b10 : 2'b01;
        t_pres = cyc;
        do @(negedge clk); while (!b_ack);
        n_b++;
        b_rail = 2'b00;
        do @(negedge clk); while (b_ack);
    endtask

    task automatic sink(input int hold, output logic [1:0] code,
                        output int t_out, output bit held);
        held = 1'b1;
        do @(negedge clk); while (y_rail == 2'b00);
        t_out = cyc;
        code  = y_rail;
        n_y++;
        repeat (hold) begin
            @(negedge clk);
            if (y_rail != code) held = 1'b0;
        end
        y_ack = 1'b1;
        do @(negedge clk); while (y_rail != 2'b00);
        y_ack = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
        $finish;
    end

    initial begin
        bit bad_ack;
        bit bad_y;
        a_rail = 2'b00;
        b_rail = 2'b00;
        y_ack  = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        // R2 during reset
        check(y_rail == 2'b00 && !a_ack && !b_ack, "R2", "outputs in reset",
              {y_rail, a_ack, b_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(y_rail == 2'b00, "R2", "y_rail after reset", y_rail, 0);
        check(!a_ack && !b_ack, "R2", "acks after reset", {a_ack, b_ack}, 0);

        // R1: the unused code 11 is never accepted
        bad_ack = 1'b0;
        bad_y   = 1'b0;
        a_rail  = 2'b11;
        repeat (8) begin
            @(negedge clk);
            if (a_ack) bad_ack = 1'b1;
            if (y_rail != 2'b00) bad_y = 1'b1;
        end
        check(!bad_ack, "R1", "ack on code 11", bad_ack, 0);
        check(!bad_y, "R1", "result on code 11", bad_y, 0);
        a_rail = 2'b00;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            logic       av;
            logic       bv;
            int         ad;
            int         bd;
            int         sd;
            int         ta;
            int         tb;
            int         tout;
            logic [1:0] code;
            logic [1:0] exp_code;
            bit         held;
            av = VEC[k][17];
            bv = VEC[k][16];
            ad = int'(VEC[k][15:10]);
            bd = int'(VEC[k][9:4]);
            sd = int'(VEC[k][3:0]);
            fork
                send_a(av, ad, ta);
                send_b(bv, bd, tb);
                sink(sd, code, tout, held);
            join
            exp_code = (av && bv) ? 2'b10 : 2'b01;
            // R6 and R1 coding of the result
            check(code == exp_code, "R6", "AND result code", code, exp_code);
            if (sd > 0)
                check(held, "R4", "result held until ack", held, 1);
            if (av && bv) begin
                check(tout > ta && tout > tb, "R5", "one before both inputs",
                      tout, (ta > tb) ? ta + 1 : tb + 1);
                if (ad == 0 && bd == 0)
                    check(tout - ta == LAT, "R9", "latency", tout - ta, LAT);
            end
            if (!av && bd >= ad + 12)
                check(tout < tb, "R7", "early zero from A", tout, tb);
            if (!bv && ad >= bd + 12)
                check(tout < ta, "R7", "early zero from B", tout, ta);
            // R8 and R10: per-operation accounting
            check(n_a == k + 1 && n_b == k + 1, "R8", "acks per operation",
                  n_a + n_b, 2 * (k + 1));
        end

        // R8, R10: nothing left over after the last operation
        bad_ack = 1'b0;
        bad_y   = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (a_ack || b_ack) bad_ack = 1'b1;
            if (y_rail != 2'b00) bad_y = 1'b1;
        end
        check(!bad_y, "R8", "extra result after drain", bad_y, 0);
        check(!bad_ack, "R10", "extra ack after drain", bad_ack, 0);
        check(n_y == NVEC, "R10", "result count", n_y, NVEC);
        check(n_a == NVEC && n_b == NVEC, "R10", "ack count", n_a + n_b, 2 * NVEC);

        summary();
        $finish;
    end

endmodule